// File: doc/BRIEF.md
# Serial EEPROM Address Pointer Unit

This unit keeps the internal byte pointer of a two-wire serial EEPROM slave that holds 1 KB, split into 8 blocks, each of 8 pages of 16 bytes. A bus front end, which is not part of this unit, turns line activity into single-cycle events: a start condition, a received device-select byte, a received word-address byte, and the completion of a data byte. The unit decodes these events, decides whether the device is selected, loads the pointer on write commands and advances it after every data byte.

Writes advance the pointer only inside the current 16-byte page. Reads advance it inside the current 128-byte block. The block used by a read is the one loaded by the most recent write command, because a read command's block bits are not used. A write command may stop after its address byte, which only sets the pointer for a later read. When a single write command carries more than 16 data bytes, the unit raises a corruption flag that lasts until the next start condition. While the power-good input is low, the whole unit stays in reset.

Top module: `eeprom_addr_ptr`

## Requirements
- R1: After `rst_n` is released with `pwr_ok` high, `addr` is 0 and both `dev_match` and `ovf_corrupt` are 0.
- R2: A device byte sets `dev_match` to 1 when its bits [7:3] equal 5'b10101 (values 0xA8 to 0xAF). Any other value sets it to 0. A start condition clears `dev_match`.
- R3: On a selected write command (bit 0 of the device byte is 0), the next address byte loads `addr` with {device bits [2:1], address byte [7:0]}. The resulting layout is block in [9:7], page in [6:4] and byte in [3:0].
- R4: Each data byte of a write command increments `addr[3:0]` modulo 16 and leaves `addr[9:4]` unchanged.
- R5: Each data byte of a read command increments `addr[6:0]` modulo 128 and leaves `addr[9:7]` unchanged.
- R6: A read device byte (bit 0 equal to 1) leaves `addr` unchanged, whatever values its bits [2:1] carry.
- R7: `ovf_corrupt` goes to 1 on the 17th data byte of one write command and stays 1 until the next start condition, which clears it.
- R8: A write command made of only a device byte and an address byte sets the pointer. A read command that follows then begins at that address.
- R9: Events do not move `addr` in these cases: data bytes after a device byte that does not match, an address byte during a read command, and a data byte that arrives before the address byte.
- R10: While `pwr_ok` is low, `addr`, `dev_match` and `ovf_corrupt` are held at 0 and all events are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_ok | input | 1 | Power good; while low, the unit is held in reset |
| start_ev | input | 1 | Start condition seen (one-cycle pulse) |
| dev_vld | input | 1 | Device-select byte received (one-cycle pulse) |
| dev_byte | input | 8 | Device-select byte, valid with `dev_vld` |
| adr_vld | input | 1 | Word-address byte received (one-cycle pulse) |
| adr_byte | input | 8 | Word-address byte, valid with `adr_vld` |
| data_done | input | 1 | Data byte transferred and acknowledged (one-cycle pulse) |
| addr | output | 10 | Current byte pointer |
| dev_match | output | 1 | Device selected in the current command |
| ovf_corrupt | output | 1 | More than 16 data bytes in the current write command |

## Verification
The assertions assume that at most one event pulse arrives in any cycle. They also assume that a command always follows the order start, device byte, optional address byte, then data bytes. Priority among simultaneous pulses is defined, but no property checks it. The stimulus drives exactly one event per cycle, and every pulse lasts one clock. The out-of-order cases, such as an address byte in a read or data before the address, still arrive one at a time, so the properties keep their premises.

// File: rtl/eeprom_addr_ptr.sv
module eeprom_addr_ptr #(
  parameter int MAX_BURST = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_ok,
  input  logic       start_ev,
  input  logic       dev_vld,
  input  logic [7:0] dev_byte,
  input  logic       adr_vld,
  input  logic [7:0] adr_byte,
  input  logic       data_done,
  output logic [9:0] addr,
  output logic       dev_match,
  output logic       ovf_corrupt
);
  localparam int CNT_W = $clog2(MAX_BURST + 1);

  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_ADR = 2'd1, PH_DATA = 2'd2, PH_SKIP = 2'd3} phase_t;

  phase_t           phase;
  logic             rd_cmd;
  logic [1:0]       hi_bits;
  logic [CNT_W-1:0] wr_cnt;

  wire clr     = !rst_n || !pwr_ok;
  wire sel_hit = (dev_byte[7:3] == 5'b10101);
  wire cnt_top = (wr_cnt == CNT_W'(MAX_BURST));

  always_ff @(posedge clk) begin
    if (clr) begin
      phase       <= PH_IDLE;
      rd_cmd      <= 1'b0;
      hi_bits     <= 2'b00;
      wr_cnt      <= '0;
      addr        <= '0;
      dev_match   <= 1'b0;
      ovf_corrupt <= 1'b0;
    end else if (start_ev) begin
      phase       <= PH_IDLE;
      wr_cnt      <= '0;
      dev_match   <= 1'b0;
      ovf_corrupt <= 1'b0;
    end else if (dev_vld && phase == PH_IDLE) begin
      dev_match <= sel_hit;
      rd_cmd    <= dev_byte[0];
      hi_bits   <= dev_byte[2:1];
      if (!sel_hit)         phase <= PH_SKIP;
      else if (dev_byte[0]) phase <= PH_DATA;
      else                  phase <= PH_ADR;
    end else if (adr_vld && phase == PH_ADR) begin
      addr  <= {hi_bits, adr_byte};
      phase <= PH_DATA;
    end else if (data_done && phase == PH_DATA) begin
      if (rd_cmd) begin
        addr[6:0] <= addr[6:0] + 7'd1;
      end else begin
        addr[3:0] <= addr[3:0] + 4'd1;
        if (cnt_top) ovf_corrupt <= 1'b1;
        else         wr_cnt      <= wr_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/eeprom_addr_ptr_chk.sv
module eeprom_addr_ptr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_ok,
  input logic       start_ev,
  input logic       dev_vld,
  input logic [7:0] dev_byte,
  input logic       adr_vld,
  input logic       data_done,
  input logic [9:0] addr,
  input logic       dev_match,
  input logic       ovf_corrupt,
  input logic [1:0] ph,
  input logic       rd
);
  a_r10_pwr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> (addr == 10'd0 && !dev_match && !ovf_corrupt));

  a_r2_select: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_ok && !start_ev && dev_vld && ph == 2'd0) |=>
      dev_match == ($past(dev_byte[7:3]) == 5'b10101));

  a_r4_page_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_ok && !start_ev && data_done && ph == 2'd2 && !rd) |=>
      addr == {$past(addr[9:4]), $past(addr[3:0]) + 4'd1});

  a_r5_block_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_ok && !start_ev && data_done && ph == 2'd2 && rd) |=>
      addr == {$past(addr[9:7]), $past(addr[6:0]) + 7'd1});

  a_r6_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_ok && dev_vld && dev_byte[0] && !adr_vld && !data_done) |=> $stable(addr));

  a_r7_ovf_on_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_corrupt) |-> $past(data_done));
endmodule

bind eeprom_addr_ptr eeprom_addr_ptr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .start_ev(start_ev),
  .dev_vld(dev_vld), .dev_byte(dev_byte), .adr_vld(adr_vld),
  .data_done(data_done), .addr(addr), .dev_match(dev_match),
  .ovf_corrupt(ovf_corrupt), .ph(phase), .rd(rd_cmd)
);

// File: tb/eeprom_addr_ptr_bench.sv
`timescale 1ns/100ps
module eeprom_addr_ptr_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_ok = 1'b1;
  logic       start_ev = 1'b0, dev_vld = 1'b0, adr_vld = 1'b0, data_done = 1'b0;
  logic [7:0] dev_byte = 8'h00, adr_byte = 8'h00;
  logic [9:0] addr;
  logic       dev_match, ovf_corrupt;
  int         n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  eeprom_addr_ptr u_eeprom_addr_ptr (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .start_ev(start_ev),
    .dev_vld(dev_vld), .dev_byte(dev_byte), .adr_vld(adr_vld),
    .adr_byte(adr_byte), .data_done(data_done), .addr(addr),
    .dev_match(dev_match), .ovf_corrupt(ovf_corrupt)
  );

  localparam logic [2:0] OP_S = 3'd0, OP_D = 3'd1, OP_A = 3'd2, OP_X = 3'd3;
  // {req, op, byte, exp addr, exp match, exp ovf}
  localparam int NV = 24;
  localparam logic [26:0] VEC [NV] = '{
    {4'd2, OP_S, 8'h00, 10'h000, 1'b0, 1'b0},
    {4'd2, OP_D, 8'hAE, 10'h000, 1'b1, 1'b0},
    {4'd3, OP_A, 8'h5E, 10'h35E, 1'b1, 1'b0},  // R3
    {4'd4, OP_X, 8'h00, 10'h35F, 1'b1, 1'b0},
    {4'd4, OP_X, 8'h00, 10'h350, 1'b1, 1'b0},  // R4 page wrap
    {4'd2, OP_S, 8'h00, 10'h350, 1'b0, 1'b0},
    {4'd6, OP_D, 8'hA9, 10'h350, 1'b1, 1'b0},  // R6
    {4'd9, OP_A, 8'h00, 10'h350, 1'b1, 1'b0},  // R9 addr byte in read
    {4'd5, OP_X, 8'h00, 10'h351, 1'b1, 1'b0},
    {4'd2, OP_S, 8'h00, 10'h351, 1'b0, 1'b0},
    {4'd3, OP_D, 8'hAC, 10'h351, 1'b1, 1'b0},
    {4'd3, OP_A, 8'h7F, 10'h27F, 1'b1, 1'b0},
    {4'd8, OP_S, 8'h00, 10'h27F, 1'b0, 1'b0},  // R8 address only
    {4'd6, OP_D, 8'hAB, 10'h27F, 1'b1, 1'b0},
    {4'd5, OP_X, 8'h00, 10'h200, 1'b1, 1'b0},  // R5 block wrap
    {4'd5, OP_X, 8'h00, 10'h201, 1'b1, 1'b0},
    {4'd2, OP_S, 8'h00, 10'h201, 1'b0, 1'b0},
    {4'd2, OP_D, 8'hB8, 10'h201, 1'b0, 1'b0},
    {4'd9, OP_X, 8'h00, 10'h201, 1'b0, 1'b0},  // R9 unselected
    {4'd2, OP_S, 8'h00, 10'h201, 1'b0, 1'b0},
    {4'd2, OP_D, 8'hA0, 10'h201, 1'b0, 1'b0},
    {4'd2, OP_S, 8'h00, 10'h201, 1'b0, 1'b0},
    {4'd2, OP_D, 8'hA8, 10'h201, 1'b1, 1'b0},
    {4'd9, OP_X, 8'h00, 10'h201, 1'b1, 1'b0}   // R9 data before address
  };

  task automatic apply(input logic [2:0] op, input logic [7:0] b);
    start_ev  = (op == OP_S);
    dev_vld   = (op == OP_D);
    adr_vld   = (op == OP_A);
    data_done = (op == OP_X);
    dev_byte  = b;
    adr_byte  = b;
    @(negedge clk);
    start_ev = 1'b0; dev_vld = 1'b0; adr_vld = 1'b0; data_done = 1'b0;
  endtask

  task automatic check(input int req, input logic [9:0] ea, input logic em, input logic eo);
    n_chk++;
    if (addr !== ea || dev_match !== em || ovf_corrupt !== eo) begin
      n_bad++;
      $display("FAIL R%0d: addr=%h match=%b ovf=%b expected addr=%h match=%b ovf=%b",
               req, addr, dev_match, ovf_corrupt, ea, em, eo);
    end
  endtask

  initial begin
    #50000;
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(1, 10'h000, 1'b0, 1'b0);  // R1

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][22:20], VEC[i][19:12]);
      check(int'(VEC[i][26:23]), VEC[i][11:2], VEC[i][1], VEC[i][0]);
    end

    // R7: 16 data bytes fine, 17th flags, start clears
    apply(OP_S, 8'h00); apply(OP_D, 8'hA8); apply(OP_A, 8'h00);
    for (int k = 0; k < 16; k++) apply(OP_X, 8'h00);
    check(7, 10'h000, 1'b1, 1'b0);
    apply(OP_X, 8'h00);
    check(7, 10'h001, 1'b1, 1'b1);
    apply(OP_X, 8'h00);
    check(7, 10'h002, 1'b1, 1'b1);
    apply(OP_S, 8'h00);
    check(7, 10'h002, 1'b0, 1'b0);

    // R10: power-good low resets and blocks events
    apply(OP_D, 8'hAE); apply(OP_A, 8'h55);
    check(3, 10'h355, 1'b1, 1'b0);
    pwr_ok = 1'b0;
    @(negedge clk);
    check(10, 10'h000, 1'b0, 1'b0);
    apply(OP_S, 8'h00); apply(OP_D, 8'hAE); apply(OP_A, 8'h55);
    check(10, 10'h000, 1'b0, 1'b0);
    pwr_ok = 1'b1;
    @(negedge clk);
    apply(OP_S, 8'h00); apply(OP_D, 8'hAA); apply(OP_A, 8'h33);
    check(3, 10'h133, 1'b1, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule